// File: doc/BRIEF.md
# Cache-Line Reload Response Sequencer

This block sits on the memory side of a processor core's read path and returns fill data for instruction-fetch and load requests. Each accepted read request carries a 5-bit core tag, a critical-quadword index, a flag selecting a full 64-byte line or a single quadword, and the 512-bit line contents. Requests wait in an arrival-ordered queue. The block serves them one at a time. For each request it gives the core advance notice through an early strobe. A valid strobe follows that carries the tag and the per-beat quadword metadata. The 128-bit data beats come last.

The core uses the early strobe to arbitrate its reload path and the valid strobe to steer each beat. A one-cycle load-pop pulse returns a read credit when a transfer has finished. Store requests are not queued. Each store is acknowledged with a store-pop pulse. Both error-reporting outputs for the reload data are held low.

Top module: `reload_seq`

## Requirements
- R1: A request with `req_valid` high and type 0x00 (instruction fetch) or 0x08 (load) is queued. Queued requests are served strictly in arrival order. Any other type code is not queued.
- R2: Up to 8 read requests can be pending. A read request that arrives while 8 are pending is dropped and produces no transfer.
- R3: A request of type 0x20 (store) makes `st_pop` high for exactly the next cycle.
- R4: A transfer begins with `rld_coming` high for one cycle. For a full line, `rld_coming` pulses again two cycles after the first pulse, one cycle ahead of the third valid beat.
- R5: `rld_valid` first goes high in the cycle after the first `rld_coming`. It stays high for 4 consecutive cycles for a full line and for 1 cycle for a single-quadword transfer.
- R6: While `rld_valid` is high, `rld_tag` equals the request tag. For a full line, `rld_qw` equals beat number minus 1 (0..3), and `rld_crit` is 1 only on the beat whose index equals the requested critical index. For a single transfer, `rld_qw` is the requested index and `rld_crit` is 1.
- R7: While `rld_valid` is low, `rld_tag` is 0x1F, `rld_qw` is 3 and `rld_crit` is 1.
- R8: Each quadword is presented on `rld_data` two cycles after its valid cycle. Quadword k is line bits [511-128k : 384-128k], so word 0 is in the most significant position. At all other times `rld_data` is zero.
- R9: `ld_pop` pulses for one cycle in the cycle after the last data beat. If another request is pending, its first `rld_coming` appears in the cycle right after that pulse. From an idle state, the first `rld_coming` appears two cycles after the request cycle.
- R10: `rld_ecc_err` and `rld_ecc_ue` are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_ttype | input | 6 | Request type code |
| req_tag | input | 5 | Core tag returned with the reload |
| req_crit_qw | input | 2 | Critical quadword index |
| req_full_line | input | 1 | 1 = four-beat line, 0 = single quadword |
| req_line | input | 512 | Line contents, word 0 at the top |
| st_pop | output | 1 | Store acknowledge pulse |
| ld_pop | output | 1 | Read credit return pulse |
| rld_coming | output | 1 | Early warning of a valid beat |
| rld_valid | output | 1 | Beat metadata valid |
| rld_tag | output | 5 | Tag of the beat |
| rld_qw | output | 2 | Quadword index of the beat |
| rld_crit | output | 1 | Critical beat flag |
| rld_data | output | 128 | Data beat |
| rld_ecc_err | output | 1 | Correctable error flag, held 0 |
| rld_ecc_ue | output | 1 | Uncorrectable error flag, held 0 |

## Verification
A wrong phase count in the sequencer shows at the ports in the very cycle it occurs. In that case `rld_valid`, `rld_coming`, the data beat or `ld_pop` each falls one cycle away from where the reference model expects it. A corrupted queue pointer or count shows later. It appears at the next transfer, as the wrong tag or line data, as an extra transfer, or as a missing transfer when the queue is expected to overflow. The reference model computes every output independently on every cycle, so each such slip is reported at its first visible cycle.

// File: rtl/reload_seq.sv
module reload_seq #(
  parameter int DEPTH = 8,
  parameter int TAG_W = 5,
  parameter int QW_W  = 128
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [5:0]          req_ttype,
  input  logic [TAG_W-1:0]    req_tag,
  input  logic [1:0]          req_crit_qw,
  input  logic                req_full_line,
  input  logic [4*QW_W-1:0]   req_line,
  output logic                st_pop,
  output logic                ld_pop,
  output logic                rld_coming,
  output logic                rld_valid,
  output logic [TAG_W-1:0]    rld_tag,
  output logic [1:0]          rld_qw,
  output logic                rld_crit,
  output logic [QW_W-1:0]     rld_data,
  output logic                rld_ecc_err,
  output logic                rld_ecc_ue
);
  localparam int LINE_W = 4 * QW_W;
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W  = $clog2(DEPTH + 1);

  typedef struct packed {
    logic [TAG_W-1:0]  tag;
    logic [1:0]        crit;
    logic              full;
    logic [LINE_W-1:0] line;
  } ent_t;

  ent_t             mem [DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic [CNT_W-1:0] cnt;
  logic             busy;
  logic [2:0]       ph;
  logic             st_q;

  ent_t head;
  assign head = mem[rp];

  wire is_rd  = req_valid && (req_ttype == 6'h00 || req_ttype == 6'h08);
  wire push   = is_rd && (cnt != CNT_W'(DEPTH));
  wire [2:0] last_ph = head.full ? 3'd6 : 3'd3;
  wire [2:0] nvld    = head.full ? 3'd4 : 3'd1;
  wire pop    = busy && (ph == last_ph + 3'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
      busy <= 1'b0; ph <= '0; st_q <= 1'b0;
    end else begin
      st_q <= req_valid && (req_ttype == 6'h20);
      if (push) begin
        mem[wp] <= '{tag: req_tag, crit: req_crit_qw, full: req_full_line, line: req_line};
        wp <= (wp == PTR_W'(DEPTH - 1)) ? '0 : wp + 1'b1;
      end
      if (pop) rp <= (rp == PTR_W'(DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt + CNT_W'(push) - CNT_W'(pop);
      if (!busy) begin
        busy <= (cnt != '0);
        ph   <= '0;
      end else if (pop) begin
        busy <= (cnt > CNT_W'(1)) || push;
        ph   <= '0;
      end else begin
        ph <= ph + 3'd1;
      end
    end
  end

  wire [1:0] vbeat = 2'(ph - 3'd1);
  wire [1:0] dbeat = 2'(ph - 3'd3);
  wire [1:0] dsel  = 2'd3 - (head.full ? dbeat : head.crit);
  wire       dphase = busy && (ph >= 3'd3) && (ph <= last_ph);

  assign st_pop      = st_q;
  assign ld_pop      = pop;
  assign rld_coming  = busy && (ph == 3'd0 || (head.full && ph == 3'd2));
  assign rld_valid   = busy && (ph >= 3'd1) && (ph <= nvld);
  assign rld_tag     = rld_valid ? head.tag : '1;
  assign rld_qw      = rld_valid ? (head.full ? vbeat : head.crit) : 2'd3;
  assign rld_crit    = rld_valid ? (!head.full || vbeat == head.crit) : 1'b1;
  assign rld_data    = dphase ? head.line[dsel*QW_W +: QW_W] : '0;
  assign rld_ecc_err = 1'b0;
  assign rld_ecc_ue  = 1'b0;
endmodule

// File: rtl/reload_seq_chk.sv
module reload_seq_chk #(
  parameter int DEPTH = 8,
  parameter int TAG_W = 5,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [5:0]       req_ttype,
  input logic             st_pop,
  input logic             ld_pop,
  input logic             rld_coming,
  input logic             rld_valid,
  input logic [TAG_W-1:0] rld_tag,
  input logic [1:0]       rld_qw,
  input logic             rld_crit,
  input logic [CNT_W-1:0] cnt
);
  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(DEPTH));
  assert_store_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ttype == 6'h20) |=> st_pop);
  assert_coming_then_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rld_coming |=> rld_valid);
  assert_valid_preceded_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rld_valid) |-> $past(rld_coming));
  assert_idle_meta_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rld_valid |-> (rld_tag == '1 && rld_qw == 2'd3 && rld_crit));
  assert_pop_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ld_pop |=> !ld_pop);
endmodule

bind reload_seq reload_seq_chk #(.DEPTH(DEPTH), .TAG_W(TAG_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ttype(req_ttype),
  .st_pop(st_pop), .ld_pop(ld_pop), .rld_coming(rld_coming), .rld_valid(rld_valid),
  .rld_tag(rld_tag), .rld_qw(rld_qw), .rld_crit(rld_crit), .cnt(cnt));

// File: tb/reload_seq_tb_top.sv
`timescale 1ns/1ps
module reload_seq_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic [5:0]   req_ttype = '0;
  logic [4:0]   req_tag = '0;
  logic [1:0]   req_crit_qw = '0;
  logic         req_full_line = 1'b0;
  logic [511:0] req_line = '0;
  logic         st_pop, ld_pop, rld_coming, rld_valid, rld_crit, rld_ecc_err, rld_ecc_ue;
  logic [4:0]   rld_tag;
  logic [1:0]   rld_qw;
  logic [127:0] rld_data;

  always #10 clk = ~clk;

  reload_seq dut_i (.*);

  typedef struct packed { logic [4:0] tag; logic [1:0] crit; logic full; logic [511:0] line; } m_t;
  m_t q[$];
  int off = -1;
  bit exp_st = 0;
  int checks = 0, errors = 0, pops = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); off = -1; exp_st = 0;
    end else begin
      bit acc, popn;
      int sz;
      sz   = q.size();
      acc  = req_valid && (req_ttype == 6'h00 || req_ttype == 6'h08) && sz < 8;
      popn = (off >= 0) && (off == (q[0].full ? 7 : 4));
      exp_st = req_valid && req_ttype == 6'h20;
      if (off < 0) off = (sz > 0) ? 0 : -1;
      else if (popn) begin
        void'(q.pop_front());
        off = (q.size() > 0 || acc) ? 0 : -1;
      end else off++;
      if (acc) q.push_back('{req_tag, req_crit_qw, req_full_line, req_line});
    end
  end

  task automatic chk(bit ok, string rq, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", rq, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    bit ec, ev, ep; logic [4:0] et; logic [1:0] eq; bit ecr; logic [127:0] ed;
    ec = 0; ev = 0; ep = 0; et = 5'h1F; eq = 2'd3; ecr = 1; ed = '0;
    if (off >= 0) begin
      m_t h; int nb;
      h = q[0]; nb = h.full ? 4 : 1;
      ec = (off == 0) || (h.full && off == 2);
      ev = off >= 1 && off <= nb;
      if (ev) begin
        et = h.tag;
        eq = h.full ? 2'(off - 1) : h.crit;
        ecr = h.full ? (2'(off - 1) == h.crit) : 1'b1;
      end
      if (off >= 3 && off <= nb + 2) begin
        int d;
        d = h.full ? off - 3 : int'(h.crit);
        ed = h.line[511 - 128*d -: 128];
      end
      ep = off == nb + 3;
    end
    if (ld_pop) pops++;
    chk(rld_coming == ec, "R4 coming", 128'(rld_coming), 128'(ec));
    chk(rld_valid == ev, "R5 valid", 128'(rld_valid), 128'(ev));
    chk(rld_tag == et, ev ? "R1 R6 tag" : "R7 idle tag", 128'(rld_tag), 128'(et));
    chk(rld_qw == eq, ev ? "R6 qw" : "R7 idle qw", 128'(rld_qw), 128'(eq));
    chk(rld_crit == ecr, ev ? "R6 crit" : "R7 idle crit", 128'(rld_crit), 128'(ecr));
    chk(rld_data == ed, "R8 data", rld_data, ed);
    chk(ld_pop == ep, "R9 ld_pop", 128'(ld_pop), 128'(ep));
    chk(st_pop == exp_st, "R3 st_pop", 128'(st_pop), 128'(exp_st));
    chk(rld_ecc_err == 0 && rld_ecc_ue == 0, "R10 ecc", 128'({rld_ecc_err, rld_ecc_ue}), 128'(0));
  end

  function automatic logic [511:0] mk_line(int n);
    logic [511:0] l;
    for (int i = 0; i < 16; i++) l[511 - 32*i -: 32] = 32'hC0DE_0000 ^ (n << 8) ^ i;
    return l;
  endfunction

  task automatic drive(logic [5:0] t, logic [4:0] tag, logic [1:0] c, bit f);
    @(negedge clk);
    req_valid = 1; req_ttype = t; req_tag = tag; req_crit_qw = c; req_full_line = f;
    req_line = mk_line(int'(tag) + 32 * int'(t));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); req_valid = 0; end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int p0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(rld_tag == 5'h1F && rld_qw == 3 && rld_crit && !rld_valid, "R7 reset idle",
        128'({rld_valid, rld_tag, rld_qw, rld_crit}), 128'({1'b0, 5'h1F, 2'd3, 1'b1}));
    drive(6'h08, 5'd3, 2'd0, 1); idle(12);
    drive(6'h00, 5'd7, 2'd2, 0); idle(8);
    drive(6'h08, 5'd9, 2'd1, 0); idle(8);
    drive(6'h20, 5'd1, 2'd0, 1); idle(3);
    p0 = pops;
    drive(6'h04, 5'd2, 2'd0, 1); drive(6'h3F, 5'd4, 2'd0, 1); idle(12);
    chk(pops == p0, "R1 unknown type ignored", 128'(pops - p0), 128'(0));
    drive(6'h08, 5'd10, 2'd3, 1); drive(6'h00, 5'd11, 2'd2, 1);
    drive(6'h20, 5'd0, 2'd0, 0); drive(6'h08, 5'd12, 2'd1, 0); idle(40);
    p0 = pops;
    for (int i = 0; i < 10; i++) drive(6'h08, 5'(16 + i), 2'(i), (i % 3) != 1);
    idle(90);
    chk(pops - p0 == 8, "R2 overflow drop", 128'(pops - p0), 128'(8));
    drive(6'h08, 5'd30, 2'd1, 1); idle(5);
    drive(6'h00, 5'd31, 2'd3, 1); idle(20);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule